// File: doc/BRIEF.md
# Frame-Synchronous Byte-Wide Scrambler

This block scrambles a byte-wide STS-48/STM-16 data stream with the frame-synchronous sequence 1 + x^6 + x^7, which repeats every 127 bits. A frame counter outside the block drives three position strobes:

- `frm_seed` marks the byte after the last C1 byte of the first overhead row. It reloads the generator with all ones, and that byte is the first one scrambled.
- `frm_run` marks bytes for which the generator advances.
- `frm_bypass` marks framing and identifier bytes (A1, A2, C1). These leave the block untouched while the generator keeps stepping.

A global `scr_en` input forces plain pass-through and leaves the generator position intact.

The keystream is produced eight bits per clock. Bit 7 of each byte is combined with the first generator output of that byte and bit 0 with the eighth. A small control state machine has two states:

- S_HUNT is entered at reset. Nothing is scrambled and the generator holds until the first seed strobe, which takes the transition HUNT_TO_LOCK.
- S_LOCK is held from then on. Every seed strobe takes the transition LOCK_RESEED, which reloads the generator and stays in S_LOCK.

A byte with neither strobe leaves the state unchanged: this is the transition HUNT_STAY or LOCK_STAY.

The output is registered, so each byte appears one clock after it is presented.

Top module: `fss_scrambler`

## Requirements
- R1: While `rst_n` is low, `dout` is 0x00 and the block is in S_HUNT.
- R2: In S_HUNT, any byte presented without `frm_seed` appears unmodified on `dout` one clock later. `frm_run` has no effect on the generator in this state.
- R3: A byte presented with `frm_seed`, `scr_en`=1 and `frm_bypass`=0 is XORed with the keystream that starts from the all-ones generator state. That keystream byte is 0xFE, and the next keystream byte is 0x04.
- R4: In S_LOCK, each byte presented with `frm_run`=1 is XORed with the next 8 keystream bits, and the generator advances 8 steps. The keystream matches a bit-serial register with feedback from stages 6 and 7 and output from stage 7, and its first bit goes to data bit 7.
- R5: A byte presented with `frm_bypass`=1 appears unmodified. The generator still advances as if the byte had been scrambled.
- R6: In S_LOCK, a byte with `frm_run`=0 and `frm_seed`=0 appears unmodified and the generator holds. The next run byte continues from the held position.
- R7: With `scr_en`=0 every byte appears unmodified. The generator keeps its normal advance, so scrambling resumes at the correct position when `scr_en` returns to 1.
- R8: A seed strobe in S_LOCK reloads the all-ones state regardless of the current position.
- R9: The keystream byte sequence repeats every 127 run bytes: run byte 127 after a seed byte again uses keystream 0xFE.
- R10: `dout` changes exactly one clock after the input byte in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_en | input | 1 | Global scramble enable; 0 gives plain pass-through |
| frm_seed | input | 1 | Generator reload strobe for the current byte |
| frm_run | input | 1 | Generator advance strobe for the current byte |
| frm_bypass | input | 1 | Current byte is emitted unscrambled |
| din | input | 8 | Input byte |
| dout | output | 8 | Registered output byte |

## Verification
The embedded properties check the following on every cycle:
- Bypass, disable and hunt-state bytes reach the output unchanged one clock later.
- A byte that neither seeds nor advances leaves the generator state unchanged.
- The generator never falls into the all-zero lock-up state.

Only the bench scenarios can show that the keystream values are correct: that the first bytes after a seed are 0xFE and 0x04, that the alignment is kept across bypass, hold and disable gaps, that a reseed in the middle of a frame lands correctly, and that the sequence repeats after 127 bytes. The bench checks these against a bit-serial model.

// File: rtl/fss_pkg.sv
package fss_pkg;

    typedef enum logic [0:0] {
        S_HUNT = 1'b0,
        S_LOCK = 1'b1
    } fss_state_e;

endpackage

// File: rtl/fss_ctl.sv
module fss_ctl
    import fss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scr_en,
    input  logic seed,
    input  logic run,
    input  logic bypass,
    output logic load,
    output logic adv,
    output logic apply,
    output logic locked
);

    fss_state_e state_q;
    fss_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT: if (seed) state_d = S_LOCK;   // HUNT_TO_LOCK
            S_LOCK: state_d = S_LOCK;             // LOCK_RESEED / LOCK_STAY
            default: state_d = S_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load   = seed;
        adv    = 1'b0;
        locked = 1'b0;
        unique case (state_q)
            S_HUNT: begin
                adv    = 1'b0;
                locked = 1'b0;
            end
            S_LOCK: begin
                adv    = run & ~seed;
                locked = 1'b1;
            end
            default: begin
                adv    = 1'b0;
                locked = 1'b0;
            end
        endcase
        apply = scr_en & ~bypass & (seed | adv);
    end

    // R5
    bypass_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> !apply);

    // R7
    disable_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_en |-> !apply);

    // R2
    hunt_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !seed) |-> (!apply && !adv));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

endmodule

// File: rtl/fss_keygen.sv
module fss_keygen #(
    parameter int LEN             = 7,
    parameter int TAP             = 6,
    parameter int W               = 8,
    parameter logic [LEN-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] ks
);

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] chain [W+1];

    assign chain[0] = load ? SEED : state_q;

    // one generator step per bit; the first output goes to the top data bit
    for (genvar i = 0; i < W; i++) begin : g_step
        assign ks[W-1-i]  = chain[i][LEN-1];
        assign chain[i+1] = {chain[i][LEN-2:0], chain[i][LEN-1] ^ chain[i][TAP-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)            state_q <= SEED;
        else if (load || adv)  state_q <= chain[W];
    end

    // R6
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(state_q));

    // R4
    no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/fss_mix.sv
module fss_mix #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         apply,
    input  logic [W-1:0] din,
    input  logic [W-1:0] ks,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= din ^ (apply ? ks : '0);
    end

    // R10
    plain_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> (dout == $past(din)));

endmodule

// File: rtl/fss_scrambler.sv
module fss_scrambler #(
    parameter int BYTE_W  = 8,
    parameter int GEN_LEN = 7,
    parameter int GEN_TAP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scr_en,
    input  logic              frm_seed,
    input  logic              frm_run,
    input  logic              frm_bypass,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    localparam logic [GEN_LEN-1:0] GEN_SEED = '1;

    logic              load;
    logic              adv;
    logic              apply;
    logic              locked;
    logic [BYTE_W-1:0] ks;

    fss_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .scr_en (scr_en),
        .seed   (frm_seed),
        .run    (frm_run),
        .bypass (frm_bypass),
        .load   (load),
        .adv    (adv),
        .apply  (apply),
        .locked (locked)
    );

    fss_keygen #(
        .LEN  (GEN_LEN),
        .TAP  (GEN_TAP),
        .W    (BYTE_W),
        .SEED (GEN_SEED)
    ) u_keygen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .ks    (ks)
    );

    fss_mix #(
        .W (BYTE_W)
    ) u_mix (
        .clk   (clk),
        .rst_n (rst_n),
        .apply (apply),
        .din   (din),
        .ks    (ks),
        .dout  (dout)
    );

    // R2
    hunt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !frm_seed) |=> (dout == $past(din)));

endmodule

// File: tb/sim_fss_scrambler.sv
module sim_fss_scrambler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scr_en = 1'b1;
    logic       frm_seed = 1'b0;
    logic       frm_run = 1'b0;
    logic       frm_bypass = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;

    int n_cmp = 0;
    int n_bad = 0;

    // bit-serial reference: bits[1]..bits[7] are stages x1..x7
    bit [7:1] rs;
    bit       m_lock;
    logic [7:0] last_ks;

    always #5 clk = ~clk;

    fss_scrambler u0 (
        .clk(clk), .rst_n(rst_n), .scr_en(scr_en), .frm_seed(frm_seed),
        .frm_run(frm_run), .frm_bypass(frm_bypass), .din(din), .dout(dout)
    );

    function automatic logic [7:0] serial_byte();
        logic [7:0] k;
        bit fb;
        for (int b = 7; b >= 0; b--) begin
            k[b] = rs[7];
            fb = rs[6] ^ rs[7];
            for (int s = 7; s > 1; s--) rs[s] = rs[s-1];
            rs[1] = fb;
        end
        return k;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit sd, input bit rn,
                        input bit bp, input string tag);
        logic [7:0] k;
        bit gen;
        logic [7:0] exp;
        k = 8'h00;
        gen = 1'b0;
        if (sd) begin
            rs = 7'h7F;
            m_lock = 1'b1;
            gen = 1'b1;
        end else if (m_lock && rn) begin
            gen = 1'b1;
        end
        if (gen) k = serial_byte();
        last_ks = k;
        exp = (gen && scr_en && !bp) ? (d ^ k) : d;
        @(negedge clk);
        din = d; frm_seed = sd; frm_run = rn; frm_bypass = bp;
        @(posedge clk);
        #1;
        check(tag, dout, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frm_seed = 0; frm_run = 0; frm_bypass = 0; din = 8'hA5;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset dout", dout, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        m_lock = 1'b0;
        rs = 7'h7F;
    endtask

    task automatic t_hunt();
        send(8'h3C, 0, 1, 0, "R2 hunt run ignored");
        send(8'hC3, 0, 0, 0, "R2 hunt plain");
        send(8'hFF, 0, 1, 0, "R10 hunt latency");
    endtask

    task automatic t_seed_run();
        send(8'h00, 1, 0, 0, "R3 seed byte");
        check("R3 first key FE", dout, 8'hFE);
        send(8'h00, 0, 1, 0, "R3 second key");
        check("R3 second key 04", dout, 8'h04);
        send(8'h5A, 0, 1, 0, "R4 run 5A");
        send(8'hFF, 0, 1, 0, "R4 run FF");
        send(8'h81, 0, 1, 0, "R4 run 81");
    endtask

    task automatic t_bypass();
        send(8'hF6, 0, 1, 1, "R5 bypass A1");
        send(8'h28, 0, 1, 1, "R5 bypass A2");
        send(8'h00, 0, 1, 0, "R5 after bypass aligned");
    endtask

    task automatic t_hold();
        send(8'h77, 0, 0, 0, "R6 hold plain");
        send(8'h12, 0, 0, 0, "R6 hold plain 2");
        send(8'h00, 0, 1, 0, "R6 resume position");
    endtask

    task automatic t_disable();
        scr_en = 1'b0;
        send(8'h99, 0, 1, 0, "R7 disabled plain");
        send(8'h66, 0, 1, 0, "R7 disabled plain 2");
        scr_en = 1'b1;
        send(8'h00, 0, 1, 0, "R7 resume aligned");
    endtask

    task automatic t_reseed();
        send(8'h00, 0, 1, 0, "R8 mid frame");
        send(8'h00, 1, 1, 0, "R8 reseed");
        check("R8 reseed key FE", dout, 8'hFE);
        send(8'h00, 0, 1, 0, "R8 after reseed");
        check("R8 after reseed 04", dout, 8'h04);
    endtask

    task automatic t_period();
        send(8'h00, 1, 0, 0, "R9 seed");
        for (int i = 1; i < 127; i++) send(8'h00, 0, 1, 0, "R9 run");
        send(8'h00, 0, 1, 0, "R9 wrap byte");
        check("R9 wrap key FE", dout, 8'hFE);
        send(8'h00, 0, 1, 0, "R9 wrap next");
        check("R9 wrap next 04", dout, 8'h04);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: expired expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        do_reset();
        t_hunt();
        t_seed_run();
        t_bypass();
        t_hold();
        t_disable();
        t_reseed();
        t_period();
        do_reset();
        t_hunt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule